// File: doc/BRIEF.md
# Multilane Receive Buffer

This block sits at the receiving end of one physical link in a flit-switched network. A fixed pool of flit storage is split evenly into a set of lanes. Each lane is an independent first-in first-out queue with its own write and read pointers. Each lane also keeps a three-state status: free, waiting (a packet head is held but no output has been assigned yet), and active. Because a packet that is blocked holds only its own lane, flits bound for other lanes can still pass it.

Every arriving flit carries a lane number and head/tail markers, and it is written into the queue of that lane. Route logic outside the block signals when a waiting lane has been given an output. The downstream switch then grants lanes one flit at a time. Each flit that leaves produces, one cycle after the grant, a forwarded flit on the output and an acknowledgment naming the lane. The upstream sender uses that acknowledgment to return one buffer credit for the lane.

Top module: `mlrb_top`

## Requirements
- R1: After synchronous reset every lane is free (state code 0) and empty, no lane is full, and `out_valid`, `ack_valid` and `wr_err` are low.
- R2: A head flit written to a free lane is stored and moves that lane to waiting (state code 1), read back two bits per lane at `lane_state[2*i+1:2*i]`.
- R3: An `assign_done` pulse moves a waiting lane to active (state code 2). On a free lane it has no effect.
- R4: A grant to an active, non-empty lane puts that lane's oldest flit, with its head/tail markers and its lane number, on the output one cycle later with `out_valid` high. In the same cycle `ack_valid` is high and `ack_lane` names the same lane.
- R5: Within a lane, flits leave in the order they arrived. Writes and grants on different lanes may be interleaved in any order without disturbing one another.
- R6: When a lane forwards a flit marked tail, that lane returns to free and is empty if nothing else was written to it.
- R7: Each lane holds TOTAL_FLITS/NUM_LANES flits. A write to a full lane raises `wr_err` for one cycle, and the flit is dropped.
- R8: A non-head flit written to a free lane, or a flit with a lane number of NUM_LANES or more, raises `wr_err` for one cycle and is dropped. The lane stays free and empty.
- R9: A grant to a lane that is empty, free or waiting is ignored. No flit and no acknowledgment are produced, and the lane keeps its contents.
- R10: When several lanes are granted in the same cycle, the lowest-numbered lane that is active and non-empty is served, and only that lane.
- R11: `lane_full[i]` is high exactly when lane i holds its full depth of flits, and `lane_empty[i]` is high exactly when it holds none. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming flit present |
| in_lane | input | LID_W | Lane number of the incoming flit |
| in_head | input | 1 | Incoming flit opens a packet |
| in_tail | input | 1 | Incoming flit closes a packet |
| in_data | input | FLIT_W | Incoming flit payload |
| assign_done | input | NUM_LANES | Per-lane pulse: output assigned to this lane |
| deq_grant | input | NUM_LANES | Per-lane dequeue grant from the switch |
| out_valid | output | 1 | Forwarded flit present |
| out_lane | output | LID_W | Lane the forwarded flit came from |
| out_head | output | 1 | Head marker of the forwarded flit |
| out_tail | output | 1 | Tail marker of the forwarded flit |
| out_data | output | FLIT_W | Forwarded flit payload |
| ack_valid | output | 1 | Reverse acknowledgment present |
| ack_lane | output | LID_W | Lane being acknowledged |
| wr_err | output | 1 | Write protocol error (flit dropped) |
| lane_state | output | 2*NUM_LANES | Per-lane state code: 0 free, 1 waiting, 2 active |
| lane_empty | output | NUM_LANES | Per-lane empty flag |
| lane_full | output | NUM_LANES | Per-lane full flag |

## Verification
The bench builds the block with a 16-flit pool, four lanes and 16-bit payloads. This gives lanes four deep, so filling one lane and then overflowing it takes only a few cycles. Four lanes are enough to interleave two packets, to grant several lanes at once with an ineligible lane among the low-numbered ones, and to show that route pulses and grants aimed at free or waiting lanes leave other lanes untouched. With four lanes the lane number is two bits wide, so every lane identifier on the input is a legal lane. The out-of-range lane check in R8 is therefore not exercised by this build.

// File: rtl/mlrb_pkg.sv
package mlrb_pkg;

    typedef enum logic [1:0] {
        LN_FREE   = 2'd0,
        LN_WAIT   = 2'd1,
        LN_ACTIVE = 2'd2
    } lane_st_e;

    typedef struct packed {
        logic head;
        logic tail;
    } flit_mark_t;

    // width of an index over n items, never below one bit
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mlrb_pool.sv
module mlrb_pool #(
    parameter int ENTRIES = 16,
    parameter int W       = 34,
    parameter int AW      = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra,
    output logic [W-1:0]  rd
);
    logic [W-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wa] <= wd;
        end
    end

    assign rd = mem[ra];
endmodule

// File: rtl/mlrb_lane.sv
module mlrb_lane
    import mlrb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int PW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_req,
    input  logic          wr_head,
    input  logic          rd_req,
    input  logic          rd_tail,
    input  logic          assign_i,
    output logic          wr_ok,
    output logic          rd_ok,
    output logic [PW-1:0] wptr,
    output logic [PW-1:0] rptr,
    output lane_st_e      state,
    output logic          empty,
    output logic          full
);
    logic [PW-1:0] occ;

    always_comb begin
        occ   = wptr - rptr;
        empty = (wptr == rptr);
        full  = (occ == PW'(DEPTH));
        wr_ok = wr_req && !full && ((state != LN_FREE) || wr_head);
        rd_ok = rd_req && !empty && (state == LN_ACTIVE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            state <= LN_FREE;
        end else begin
            if (wr_ok) wptr <= wptr + PW'(1);
            if (rd_ok) rptr <= rptr + PW'(1);
            case (state)
                LN_FREE:   if (wr_ok && wr_head) state <= LN_WAIT;
                LN_WAIT:   if (assign_i)         state <= LN_ACTIVE;
                LN_ACTIVE: if (rd_ok && rd_tail) state <= LN_FREE;
                default:                         state <= LN_FREE;
            endcase
        end
    end

    // R11
    no_full_empty_chk: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    // R7
    occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (wptr - rptr) <= PW'(DEPTH));

    // R3
    no_skip_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (state == LN_FREE) |=> (state != LN_ACTIVE));

    // R6
    tail_release_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_ok && rd_tail) |=> (state == LN_FREE));

    // R5
    wptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ok |=> (wptr == $past(wptr) + PW'(1)));
endmodule

// File: rtl/mlrb_egress.sv
module mlrb_egress #(
    parameter int FLIT_W = 32,
    parameter int LID_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [LID_W-1:0]  fire_lane,
    input  logic              fire_head,
    input  logic              fire_tail,
    input  logic [FLIT_W-1:0] fire_data,
    input  logic              err_in,
    output logic              out_valid,
    output logic [LID_W-1:0]  out_lane,
    output logic              out_head,
    output logic              out_tail,
    output logic [FLIT_W-1:0] out_data,
    output logic              ack_valid,
    output logic [LID_W-1:0]  ack_lane,
    output logic              wr_err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_lane  <= '0;
            out_head  <= 1'b0;
            out_tail  <= 1'b0;
            out_data  <= '0;
            ack_valid <= 1'b0;
            ack_lane  <= '0;
            wr_err    <= 1'b0;
        end else begin
            out_valid <= fire;
            ack_valid <= fire;
            wr_err    <= err_in;
            if (fire) begin
                out_lane <= fire_lane;
                out_head <= fire_head;
                out_tail <= fire_tail;
                out_data <= fire_data;
                ack_lane <= fire_lane;
            end
        end
    end
endmodule

// File: rtl/mlrb_top.sv
module mlrb_top
    import mlrb_pkg::*;
#(
    parameter int TOTAL_FLITS = 16,
    parameter int NUM_LANES   = 4,
    parameter int FLIT_W      = 32,
    localparam int DEPTH      = TOTAL_FLITS / NUM_LANES,
    localparam int PW         = $clog2(DEPTH) + 1,
    localparam int LID_W      = idx_w(NUM_LANES),
    localparam int AW         = idx_w(TOTAL_FLITS),
    localparam int SW         = FLIT_W + 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [LID_W-1:0]       in_lane,
    input  logic                   in_head,
    input  logic                   in_tail,
    input  logic [FLIT_W-1:0]      in_data,
    input  logic [NUM_LANES-1:0]   assign_done,
    input  logic [NUM_LANES-1:0]   deq_grant,
    output logic                   out_valid,
    output logic [LID_W-1:0]       out_lane,
    output logic                   out_head,
    output logic                   out_tail,
    output logic [FLIT_W-1:0]      out_data,
    output logic                   ack_valid,
    output logic [LID_W-1:0]       ack_lane,
    output logic                   wr_err,
    output logic [2*NUM_LANES-1:0] lane_state,
    output logic [NUM_LANES-1:0]   lane_empty,
    output logic [NUM_LANES-1:0]   lane_full
);
    logic                 lane_hit;
    logic [LID_W-1:0]     wlane;
    logic [NUM_LANES-1:0] wr_req_v, wr_ok_v, rd_ok_v, elig, pick;
    logic [LID_W-1:0]     pick_lane;
    logic [PW-1:0]        wptr_a [NUM_LANES];
    logic [PW-1:0]        rptr_a [NUM_LANES];
    lane_st_e             st_a   [NUM_LANES];
    logic [AW-1:0]        wa, ra;
    logic [SW-1:0]        wd, rd;
    flit_mark_t           in_mark, rd_mark;

    always_comb begin
        lane_hit = in_valid && (int'(in_lane) < NUM_LANES);
        wlane    = lane_hit ? in_lane : '0;
        in_mark  = '{head: in_head, tail: in_tail};
        wd       = {in_mark, in_data};
        wa       = AW'(int'(wlane) * DEPTH + int'(wptr_a[wlane]) % DEPTH);
    end

    // lowest-numbered eligible lane wins
    always_comb begin
        pick      = '0;
        pick_lane = '0;
        for (int i = NUM_LANES - 1; i >= 0; i--) begin
            if (elig[i]) begin
                pick      = '0;
                pick[i]   = 1'b1;
                pick_lane = LID_W'(i);
            end
        end
        ra      = AW'(int'(pick_lane) * DEPTH + int'(rptr_a[pick_lane]) % DEPTH);
        rd_mark = rd[SW-1 -: 2];
    end

    generate
        for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
            assign wr_req_v[i] = lane_hit && (in_lane == LID_W'(i));
            assign elig[i]     = deq_grant[i] && !lane_empty[i] && (st_a[i] == LN_ACTIVE);
            assign lane_state[2*i +: 2] = st_a[i];

            mlrb_lane #(
                .DEPTH (DEPTH),
                .PW    (PW)
            ) u_lane (
                .clk      (clk),
                .rst      (rst),
                .wr_req   (wr_req_v[i]),
                .wr_head  (in_head),
                .rd_req   (pick[i]),
                .rd_tail  (rd_mark.tail),
                .assign_i (assign_done[i]),
                .wr_ok    (wr_ok_v[i]),
                .rd_ok    (rd_ok_v[i]),
                .wptr     (wptr_a[i]),
                .rptr     (rptr_a[i]),
                .state    (st_a[i]),
                .empty    (lane_empty[i]),
                .full     (lane_full[i])
            );
        end
    endgenerate

    mlrb_pool #(
        .ENTRIES (TOTAL_FLITS),
        .W       (SW),
        .AW      (AW)
    ) u_pool (
        .clk (clk),
        .we  (|wr_ok_v),
        .wa  (wa),
        .wd  (wd),
        .ra  (ra),
        .rd  (rd)
    );

    mlrb_egress #(
        .FLIT_W (FLIT_W),
        .LID_W  (LID_W)
    ) u_egress (
        .clk       (clk),
        .rst       (rst),
        .fire      (|rd_ok_v),
        .fire_lane (pick_lane),
        .fire_head (rd_mark.head),
        .fire_tail (rd_mark.tail),
        .fire_data (rd[FLIT_W-1:0]),
        .err_in    (in_valid && !(|wr_ok_v)),
        .out_valid (out_valid),
        .out_lane  (out_lane),
        .out_head  (out_head),
        .out_tail  (out_tail),
        .out_data  (out_data),
        .ack_valid (ack_valid),
        .ack_lane  (ack_lane),
        .wr_err    (wr_err)
    );

    // R10
    single_read_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rd_ok_v));

    // R4
    ack_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (|rd_ok_v) |=> (ack_valid && out_valid));

    // R9
    idle_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
        !(|deq_grant) |=> !ack_valid);
endmodule

// File: tb/mlrb_top_test.sv
module mlrb_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int TOTAL      = 16;
    localparam int LANES      = 4;
    localparam int FW         = 16;
    localparam int LW         = 2;

    logic            clk = 1'b0;
    logic            rst;
    logic            in_valid, in_head, in_tail;
    logic [LW-1:0]   in_lane;
    logic [FW-1:0]   in_data;
    logic [LANES-1:0] assign_done, deq_grant;
    logic            out_valid, out_head, out_tail, ack_valid, wr_err;
    logic [LW-1:0]   out_lane, ack_lane;
    logic [FW-1:0]   out_data;
    logic [2*LANES-1:0] lane_state;
    logic [LANES-1:0] lane_empty, lane_full;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mlrb_top #(.TOTAL_FLITS(TOTAL), .NUM_LANES(LANES), .FLIT_W(FW)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_lane(in_lane),
        .in_head(in_head), .in_tail(in_tail), .in_data(in_data),
        .assign_done(assign_done), .deq_grant(deq_grant),
        .out_valid(out_valid), .out_lane(out_lane), .out_head(out_head),
        .out_tail(out_tail), .out_data(out_data), .ack_valid(ack_valid),
        .ack_lane(ack_lane), .wr_err(wr_err), .lane_state(lane_state),
        .lane_empty(lane_empty), .lane_full(lane_full)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] st(input int l);
        return lane_state[2*l +: 2];
    endfunction

    task automatic clear_in();
        in_valid = 0; in_lane = '0; in_head = 0; in_tail = 0; in_data = '0;
        assign_done = '0; deq_grant = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        clear_in();
    endtask

    task automatic send(input int l, input logic h, input logic t, input logic [FW-1:0] d);
        in_valid = 1; in_lane = LW'(l); in_head = h; in_tail = t; in_data = d;
        tick();
    endtask

    task automatic route(input logic [LANES-1:0] m);
        assign_done = m;
        tick();
    endtask

    task automatic grant(input logic [LANES-1:0] m);
        deq_grant = m;
        tick();
    endtask

    task automatic expect_flit(input string req, input int l, input logic [FW-1:0] d,
                               input logic h, input logic t);
        chk({req, " out_valid"}, 32'(out_valid), 32'd1);
        chk({req, " out_data"}, 32'(out_data), 32'(d));
        chk({req, " out_lane"}, 32'(out_lane), 32'(l));
        chk({req, " out_head"}, 32'(out_head), 32'(h));
        chk({req, " out_tail"}, 32'(out_tail), 32'(t));
        chk({req, " ack_valid"}, 32'(ack_valid), 32'd1);
        chk({req, " ack_lane"}, 32'(ack_lane), 32'(l));
    endtask

    task automatic t_reset();
        rst = 1; clear_in();
        repeat (3) @(posedge clk);
        #1; rst = 0;
        // R1
        chk("R1 lane_state", 32'(lane_state), 32'd0);
        chk("R1 lane_empty", 32'(lane_empty), 32'hF);
        chk("R1 lane_full", 32'(lane_full), 32'd0);
        chk("R1 out_valid", 32'(out_valid), 32'd0);
        chk("R1 ack_valid", 32'(ack_valid), 32'd0);
        chk("R1 wr_err", 32'(wr_err), 32'd0);
    endtask

    task automatic t_alloc_route();
        send(1, 1, 0, 16'hA001);
        // R2
        chk("R2 lane1 waiting", 32'(st(1)), 32'd1);
        chk("R2 lane1 not empty", 32'(lane_empty[1]), 32'd0);
        chk("R2 no error", 32'(wr_err), 32'd0);
        grant(4'b0010);
        // R9 grant to waiting lane
        chk("R9 waiting grant no flit", 32'(out_valid), 32'd0);
        chk("R9 waiting grant no ack", 32'(ack_valid), 32'd0);
        chk("R9 waiting lane kept", 32'(lane_empty[1]), 32'd0);
        route(4'b0100);
        // R3 route pulse on free lane
        chk("R3 free lane unchanged", 32'(st(2)), 32'd0);
        route(4'b0010);
        chk("R3 lane1 active", 32'(st(1)), 32'd2);
    endtask

    task automatic t_fifo_tail();
        send(1, 0, 0, 16'hA002);
        send(1, 0, 1, 16'hA003);
        grant(4'b0010);
        expect_flit("R4 first", 1, 16'hA001, 1, 0);
        grant(4'b0010);
        expect_flit("R5 second", 1, 16'hA002, 0, 0);
        grant(4'b0010);
        expect_flit("R5 third", 1, 16'hA003, 0, 1);
        // R6
        chk("R6 lane1 free", 32'(st(1)), 32'd0);
        chk("R6 lane1 empty", 32'(lane_empty[1]), 32'd1);
    endtask

    task automatic t_interleave();
        send(0, 1, 0, 16'hB001);
        send(3, 1, 0, 16'hC001);
        send(0, 0, 1, 16'hB002);
        send(3, 0, 1, 16'hC002);
        route(4'b1001);
        grant(4'b1000);
        expect_flit("R5 lane3 first", 3, 16'hC001, 1, 0);
        grant(4'b0001);
        expect_flit("R5 lane0 first", 0, 16'hB001, 1, 0);
        grant(4'b0001);
        expect_flit("R5 lane0 tail", 0, 16'hB002, 0, 1);
        chk("R6 lane0 free", 32'(st(0)), 32'd0);
        chk("R5 lane3 still active", 32'(st(3)), 32'd2);
        grant(4'b1000);
        expect_flit("R5 lane3 tail", 3, 16'hC002, 0, 1);
    endtask

    task automatic t_full();
        send(2, 1, 0, 16'hD000);
        send(2, 0, 0, 16'hD001);
        send(2, 0, 0, 16'hD002);
        chk("R11 not yet full", 32'(lane_full[2]), 32'd0);
        send(2, 0, 1, 16'hD003);
        // R11 / R7 depth is TOTAL/LANES = 4
        chk("R11 lane2 full", 32'(lane_full[2]), 32'd1);
        send(2, 0, 0, 16'hD004);
        // R7
        chk("R7 overflow error", 32'(wr_err), 32'd1);
        chk("R7 still full", 32'(lane_full[2]), 32'd1);
        route(4'b0100);
        chk("R7 error is one cycle", 32'(wr_err), 32'd0);
        grant(4'b0100);
        expect_flit("R7 drain0", 2, 16'hD000, 1, 0);
        chk("R11 full drops", 32'(lane_full[2]), 32'd0);
        for (int k = 1; k < 4; k++) begin
            grant(4'b0100);
            expect_flit("R7 drain", 2, FW'(16'hD000 + k), 0, k == 3);
        end
        chk("R6 lane2 free", 32'(st(2)), 32'd0);
        grant(4'b0100);
        // R9 empty lane grant ignored (dropped D004 never appears)
        chk("R9 empty grant no flit", 32'(out_valid), 32'd0);
        chk("R9 empty grant no ack", 32'(ack_valid), 32'd0);
    endtask

    task automatic t_nonhead();
        send(0, 0, 0, 16'hE0E0);
        // R8
        chk("R8 body on free lane error", 32'(wr_err), 32'd1);
        chk("R8 lane0 free", 32'(st(0)), 32'd0);
        chk("R8 lane0 empty", 32'(lane_empty[0]), 32'd1);
    endtask

    task automatic t_priority();
        send(1, 1, 1, 16'hF001);
        send(2, 1, 1, 16'hF002);
        route(4'b0110);
        grant(4'b0111);
        // R10 lane0 granted but free, lane1 lowest eligible
        expect_flit("R10 lowest eligible", 1, 16'hF001, 1, 1);
        chk("R10 lane2 untouched", 32'(lane_empty[2]), 32'd0);
        grant(4'b0110);
        expect_flit("R10 next lane", 2, 16'hF002, 1, 1);
        chk("R10 all empty", 32'(lane_empty), 32'hF);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_alloc_route();
        t_fifo_tail();
        t_interleave();
        t_full();
        t_nonhead();
        t_priority();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule